// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single line. A clock running at sixteen times the bit rate paces it, so each bit on the line lasts sixteen clock periods. A control word sets the shape of every frame: the character length (5 to 8 bits), whether a parity bit is sent, whether that parity is even or odd, and the stop period. The stop period is one bit, or a longer period that is one and a half bits for 5-bit characters and two bits for any other length.

Characters are written into a one-entry holding buffer. A shifter takes the character from the buffer and sends a low start bit, then the data bits least significant first, then the optional parity bit, then a high stop period. The buffer empties as soon as the shifter takes its character. The next character can therefore be written while the current one is still being sent, and it follows with no idle gap. The control word is read when a character moves into the shifter, so changing the control word never disturbs a frame that is already on the line. Two flags report whether the buffer is empty and whether the shifter is empty.

Top module: `serial_tx_engine`

## Requirements
- R1: While reset is held and right after it, tx_out is high, buf_empty is high and shift_empty is high. The reset control word is 8 bits, one stop bit and parity off.
- R2: Every bit on tx_out lasts exactly 16 clock periods. A frame is a low start bit, then the data bits least significant first, then the parity bit if enabled, then a high stop period.
- R3: cfg_len selects the character length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. cfg_len[0] is the first select input.
- R4: Bits of buf_data at and above the programmed length have no effect on tx_out.
- R5: With cfg_stop_long low the stop period is 16 clock periods. With it high the stop period is 24 clock periods for 5-bit characters and 32 for any other length.
- R6: With cfg_par_off high no parity bit is sent, and the stop period follows the last data bit directly.
- R7: With cfg_par_off low a parity bit follows the data. With cfg_par_even high it makes the number of ones across data and parity even; with cfg_par_even low it makes that number odd.
- R8: The control word register takes its inputs on every clock edge at which cfg_load is high. The shifter samples the register when it takes a character, so loading a new word during a frame leaves that frame unchanged.
- R9: buf_empty goes low one edge after a write with buf_wr and stays low until the shifter takes the character. It goes high on the same edge that drives the start bit onto tx_out.
- R10: shift_empty goes low on the edge that takes a character and goes high on the edge that ends the stop period when no character is waiting. tx_out is high whenever shift_empty is high.
- R11: A character written while the shifter is busy starts its start bit on the edge that ends the current stop period, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Control word register load enable |
| cfg_len | input | 2 | Character length select |
| cfg_stop_long | input | 1 | Long stop period select |
| cfg_par_off | input | 1 | Parity suppress |
| cfg_par_even | input | 1 | Even parity when high, odd when low |
| buf_wr | input | 1 | Write strobe for the holding buffer |
| buf_data | input | 8 | Character to send |
| buf_empty | output | 1 | Holding buffer empty |
| shift_empty | output | 1 | Shifter idle, line at rest |
| tx_out | output | 1 | Serial output line |

## Verification
A wrong bit-timer count or a wrong phase step shows on tx_out within one bit time, at most 16 clock periods after the fault, as a level that does not match the expected frame. A wrong latched length, parity or stop selection appears at the first slot that depends on it, and a wrong hand-over between buffer and shifter shows in buf_empty or shift_empty on the edge that ends a stop period. The bench compares tx_out with a frame model on every clock period and checks both flags at each hand-over. This includes back-to-back frames in which the control word is reloaded mid-frame.

// File: rtl/tx_pkg.sv
package tx_pkg;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       stop_long;
    logic       par_off;
    logic       par_even;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{len_sel: 2'b11, stop_long: 1'b0,
                                    par_off: 1'b1, par_even: 1'b0};

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

endpackage

// File: rtl/tx_cfg_reg.sv
module tx_cfg_reg
  import tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  tx_cfg_t cfg_d,
  output tx_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= CFG_RESET;
    else if (load) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic [DATA_W-1:0] dout,
  output logic              empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      empty <= 1'b1;
    end else if (wr) begin
      dout  <= din;
      empty <= 1'b0;
    end else if (take) begin
      empty <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tx_cfg_t           cfg,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              tx_out,
  output logic              shift_empty
);
  localparam int CNT_W   = $clog2(2 * OVS);
  localparam int LEN_W   = $clog2(DATA_W + 1);
  localparam int MIN_LEN = DATA_W - 3;

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [LEN_W-1:0]  bits_left;
  logic              par_en_q;
  logic              par_bit_q;
  logic [CNT_W-1:0]  stop_lim_q;
  logic [CNT_W-1:0]  limit;
  logic              last;

  logic [LEN_W-1:0]  nbits;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked;
  logic [CNT_W-1:0]  stop_lim_d;

  assign nbits = LEN_W'(MIN_LEN) + LEN_W'(cfg.len_sel);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    assign mask[gi] = (LEN_W'(gi) < nbits);
  end

  assign masked = hold_data & mask;

  always_comb begin
    if (!cfg.stop_long)          stop_lim_d = CNT_W'(OVS - 1);
    else if (nbits == LEN_W'(MIN_LEN)) stop_lim_d = CNT_W'(OVS + OVS / 2 - 1);
    else                         stop_lim_d = CNT_W'(2 * OVS - 1);
  end

  assign limit = (state == ST_STOP) ? stop_lim_q : CNT_W'(OVS - 1);
  assign take  = hold_full && ((state == ST_IDLE) || (state == ST_STOP && last));

  tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state != ST_IDLE),
    .limit(limit),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      bits_left   <= '0;
      par_en_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      stop_lim_q  <= '0;
      tx_out      <= 1'b1;
      shift_empty <= 1'b1;
    end else if (take) begin
      state       <= ST_START;
      shreg       <= masked;
      bits_left   <= nbits;
      par_en_q    <= !cfg.par_off;
      par_bit_q   <= (^masked) ^ ~cfg.par_even;
      stop_lim_q  <= stop_lim_d;
      tx_out      <= 1'b0;
      shift_empty <= 1'b0;
    end else if (last) begin
      unique case (state)
        ST_START, ST_DATA: begin
          if (bits_left != '0) begin
            state     <= ST_DATA;
            tx_out    <= shreg[0];
            shreg     <= shreg >> 1;
            bits_left <= bits_left - 1'b1;
          end else if (par_en_q) begin
            state  <= ST_PAR;
            tx_out <= par_bit_q;
          end else begin
            state  <= ST_STOP;
            tx_out <= 1'b1;
          end
        end
        ST_PAR: begin
          state  <= ST_STOP;
          tx_out <= 1'b1;
        end
        ST_STOP: begin
          state       <= ST_IDLE;
          tx_out      <= 1'b1;
          shift_empty <= 1'b1;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop_long,
  input  logic              cfg_par_off,
  input  logic              cfg_par_even,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              tx_out
);
  tx_cfg_t           cfg_d;
  tx_cfg_t           cfg_q;
  logic [DATA_W-1:0] hold_data;
  logic              take;

  assign cfg_d = '{len_sel: cfg_len, stop_long: cfg_stop_long,
                   par_off: cfg_par_off, par_even: cfg_par_even};

  tx_cfg_reg u_cfg (
    .clk  (clk),
    .rst  (rst),
    .load (cfg_load),
    .cfg_d(cfg_d),
    .cfg_q(cfg_q)
  );

  tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk  (clk),
    .rst  (rst),
    .wr   (buf_wr),
    .din  (buf_data),
    .take (take),
    .dout (hold_data),
    .empty(buf_empty)
  );

  tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .cfg        (cfg_q),
    .hold_full  (!buf_empty),
    .hold_data  (hold_data),
    .take       (take),
    .tx_out     (tx_out),
    .shift_empty(shift_empty)
  );
endmodule

// File: rtl/serial_tx_engine_chk.sv
module serial_tx_engine_chk (
  input logic clk,
  input logic rst,
  input logic buf_wr,
  input logic buf_empty,
  input logic shift_empty,
  input logic tx_out
);
  assert_idle_line_high_R10: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> tx_out);

  assert_start_on_busy_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) |-> !tx_out);

  assert_take_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> !shift_empty);

  assert_write_fills_R9: assert property (@(posedge clk) disable iff (rst)
    buf_wr |=> !buf_empty);

  assert_empty_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (buf_empty && !buf_wr) |=> buf_empty);

  assert_idle_no_wait_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_empty) |-> buf_empty);
endmodule

bind serial_tx_engine serial_tx_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .buf_wr     (buf_wr),
  .buf_empty  (buf_empty),
  .shift_empty(shift_empty),
  .tx_out     (tx_out)
);

// File: tb/sim_serial_tx_engine.sv
`timescale 1ns/1ps
module sim_serial_tx_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_stop_long = 1'b0;
  logic       cfg_par_off = 1'b1;
  logic       cfg_par_even = 1'b0;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_data = 8'h00;
  logic       buf_empty, shift_empty, tx_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  serial_tx_engine u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_len(cfg_len),
    .cfg_stop_long(cfg_stop_long), .cfg_par_off(cfg_par_off),
    .cfg_par_even(cfg_par_even), .buf_wr(buf_wr), .buf_data(buf_data),
    .buf_empty(buf_empty), .shift_empty(shift_empty), .tx_out(tx_out)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int char_len(input logic [1:0] ls);
    return 5 + int'(ls);
  endfunction

  function automatic int frame_len(input logic [1:0] ls, input logic sl, input logic po);
    int n = char_len(ls);
    int stop = sl ? ((n == 5) ? 24 : 32) : 16;
    return 16 * (1 + n + (po ? 0 : 1)) + stop;
  endfunction

  function automatic logic exp_level(input int k, input logic [7:0] d, input logic [1:0] ls,
                                     input logic po, input logic pe);
    int n = char_len(ls);
    int slot = k / 16;
    logic [7:0] m = d & 8'((9'h1 << n) - 1);
    if (slot == 0) return 1'b0;
    if (slot <= n) return m[slot-1];
    if (!po && slot == n + 1) return (^m) ^ ~pe;
    return 1'b1;
  endfunction

  function automatic string slot_tag(input int k, input logic [7:0] d, input logic [1:0] ls,
                                     input logic po);
    int n = char_len(ls);
    int slot = k / 16;
    if (slot == 0) return "R2";
    if (slot <= n) return ((d >> n) != 0) ? "R4" : "R3";
    if (!po && slot == n + 1) return "R7";
    if (po && slot == n + 1) return "R6";
    return "R5";
  endfunction

  // Frame in flight: k = 0 is the first period of the start bit.
  task automatic run_frame(input logic [7:0] d, input logic [1:0] ls, input logic sl,
                           input logic po, input logic pe, input bit chain,
                           input logic [7:0] dn, input logic [1:0] lsn, input logic sln,
                           input logic pon, input logic pen, input bit tag_r8);
    int total = frame_len(ls, sl, po);
    for (int k = 0; k < total; k++) begin
      string tg = slot_tag(k, d, ls, po);
      if (tag_r8 && k >= 4) tg = "R8";
      chk(tx_out, exp_level(k, d, ls, po, pe), tg, $sformatf("tx_out k=%0d", k));
      if (chain) begin
        if (k == 3) begin
          cfg_len = lsn; cfg_stop_long = sln; cfg_par_off = pon; cfg_par_even = pen;
          cfg_load = 1'b1;
        end
        if (k == 4) cfg_load = 1'b0;
        if (k == 6) begin buf_wr = 1'b1; buf_data = dn; end
        if (k == 7) buf_wr = 1'b0;
        if (k == 8) chk(buf_empty, 1'b0, "R9", "buf full while busy");
      end
      if (k == total - 1) chk(shift_empty, 1'b0, "R10", "busy in last stop period");
      @(posedge clk); @(negedge clk);
    end
    if (chain) begin
      chk(tx_out, 1'b0, "R11", "next start bit without gap");
      chk(buf_empty, 1'b1, "R9", "buf empties on hand-over");
      chk(shift_empty, 1'b0, "R11", "shifter stays busy");
    end else begin
      chk(shift_empty, 1'b1, "R10", "shift_empty after stop");
      chk(buf_empty, 1'b1, "R10", "buf empty at idle");
      chk(tx_out, 1'b1, "R10", "line idles high");
    end
  endtask

  // Load control word, write one character from idle, align to k = 0.
  task automatic kick(input logic [7:0] d, input logic [1:0] ls, input logic sl,
                      input logic po, input logic pe);
    cfg_len = ls; cfg_stop_long = sl; cfg_par_off = po; cfg_par_even = pe; cfg_load = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_load = 1'b0;
    buf_wr = 1'b1; buf_data = d;
    @(posedge clk); @(negedge clk);
    buf_wr = 1'b0;
    chk(buf_empty, 1'b0, "R9", "buf full after write");
    chk(shift_empty, 1'b1, "R10", "idle before hand-over");
    @(posedge clk); @(negedge clk);
    chk(buf_empty, 1'b1, "R9", "buf empties with start bit");
    chk(shift_empty, 1'b0, "R10", "busy after take");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_out, 1'b1, "R1", "tx_out in reset");
    chk(buf_empty, 1'b1, "R1", "buf_empty in reset");
    chk(shift_empty, 1'b1, "R1", "shift_empty in reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(tx_out, 1'b1, "R1", "tx_out after reset");

    // R1: reset word (8 bits, 1 stop, no parity) used without any load
    buf_wr = 1'b1; buf_data = 8'hA5;
    @(posedge clk); @(negedge clk);
    buf_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(shift_empty, 1'b0, "R1", "started with reset word");
    run_frame(8'hA5, 2'b11, 1'b0, 1'b1, 1'b0, 0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0, 0);

    // R5: 1.5 stop bits on 5-bit characters, upper bits ignored (R4)
    kick(8'hF6, 2'b00, 1'b1, 1'b1, 1'b0);
    run_frame(8'hF6, 2'b00, 1'b1, 1'b1, 1'b0, 0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0, 0);
    // R5/R7: 2 stop bits, 8-bit, even parity
    kick(8'h3C, 2'b11, 1'b1, 1'b0, 1'b1);
    run_frame(8'h3C, 2'b11, 1'b1, 1'b0, 1'b1, 0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0, 0);
    // R7: odd parity, 6-bit, all ones
    kick(8'hFF, 2'b01, 1'b0, 1'b0, 1'b0);
    run_frame(8'hFF, 2'b01, 1'b0, 1'b0, 1'b0, 0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0, 0);
    // R4: 5-bit with only upper bits set, sends all-zero data
    kick(8'hE0, 2'b00, 1'b0, 1'b0, 1'b1);
    run_frame(8'hE0, 2'b00, 1'b0, 1'b0, 1'b1, 0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0, 0);

    // R8/R11: directed chain, reload word mid-frame with very different shape
    kick(8'h96, 2'b11, 1'b1, 1'b0, 1'b1);
    run_frame(8'h96, 2'b11, 1'b1, 1'b0, 1'b1, 1, 8'h1B, 2'b00, 1'b0, 1'b1, 1'b0, 1);
    run_frame(8'h1B, 2'b00, 1'b0, 1'b1, 1'b0, 0, 8'h0, 2'b0, 1'b0, 1'b0, 1'b0, 0);

    // Random back-to-back frames
    begin
      logic [7:0] d  = 8'($urandom);
      logic [1:0] ls = 2'($urandom);
      logic sl = 1'($urandom), po = 1'($urandom), pe = 1'($urandom);
      kick(d, ls, sl, po, pe);
      for (int i = 0; i < 40; i++) begin
        logic [7:0] dn  = 8'($urandom);
        logic [1:0] lsn = 2'($urandom);
        logic sln = 1'($urandom), pon = 1'($urandom), pen = 1'($urandom);
        bit more = (i != 39);
        run_frame(d, ls, sl, po, pe, more, dn, lsn, sln, pon, pen, 0);
        d = dn; ls = lsn; sl = sln; po = pon; pe = pen;
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule